// File: doc/BRIEF.md
# DMA Request and Burst Controller

This block decides when a byte-wide FIFO inside a bus-protocol controller asks an external DMA engine for service. It looks at how many bytes the FIFO can move in the current direction, the remaining byte count of the transfer, and whether the bus is in a data phase. From these it raises a request. The request is either a single-byte handshake or an eight-byte burst. The active-low acknowledge and the host read and write strobes arrive asynchronously. They are resynchronized, and their edges count the bytes moved.

During data phases, an optional deep threshold holds the request back until a full burst's worth of bytes can move. Every other phase uses a one-byte threshold. Near the end of a transfer, fewer than a burst's worth of bytes may remain. The block then finishes with single requests. As initiator, a phase change that arrives before the first acknowledge of a burst request demotes that request to a single transfer. In multiplexed host-bus mode, the acknowledge is held across the burst and the read strobe marks each byte. In nonmultiplexed mode, the acknowledge itself toggles per byte.

The block also caps the offered synchronous offset at seven whenever the deep threshold is enabled.

Top module: `dma_req_ctrl`

## Requirements
- R1: With `deep_thresh_en`=1 and `data_phase`=1, a request is raised only when `fifo_avail` is at least 8, or at least `bytes_left` when fewer than 8 bytes remain. With either of them 0, `fifo_avail` of at least 1 is enough.
- R2: `xfer_start` loads `xfer_count` into `bytes_left`. Each completed byte decrements `bytes_left`. `dreq` is never held while `bytes_left` is 0.
- R3: When `burst_en`=1, `bytes_left` is at least 8 and `fifo_avail` is at least 8 as a request starts, the request is a burst (`burst_active`=1). `dreq` then stays high for exactly 8 completed bytes and drops in the cycle after the eighth.
- R4: A request started with fewer than 8 bytes left, or with `burst_en`=0, is a single request that serves one byte.
- R5: A single request drops `dreq` on the synchronized falling edge of `ack_n`. No new request starts while the synchronized `ack_n` is low.
- R6: With `initiator`=1, a `phase_change` pulse during a burst request before its first acknowledge turns it into a single request. With `initiator`=0, the burst is unaffected.
- R7: `offset_lim` equals `offset_req`, except that it is 7 when `deep_thresh_en`=1 and `offset_req` is above 7.
- R8: With `dir_read`=0, a byte completes on each falling edge of `wr_n` while `ack_n` is low. `ack_n` may stay low across a burst. `rd_data_oe` stays 0.
- R9: With `dir_read`=1 and `mux_bus`=1, a byte completes on each falling edge of `rd_n` while `ack_n` is low. `rd_data_oe` is 1 only while both `ack_n` and `rd_n` are low.
- R10: With `dir_read`=1 and `mux_bus`=0, a byte completes on each falling edge of `ack_n`. `rd_data_oe` is 1 whenever `ack_n` is low.
- R11: While `rst_n` is low at a clock edge, `dreq`, `burst_active` and `bytes_left` clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_start | input | 1 | Load the byte count and abort any request |
| xfer_count | input | CNT_W | Byte count of the new transfer |
| fifo_avail | input | LVL_W | Bytes the FIFO can move in the current direction |
| data_phase | input | 1 | Bus is in a data phase |
| initiator | input | 1 | Controller acts as initiator |
| phase_change | input | 1 | One-cycle pulse on a bus phase change |
| deep_thresh_en | input | 1 | Enable the burst-sized request threshold |
| burst_en | input | 1 | Allow burst requests |
| mux_bus | input | 1 | Multiplexed host-bus mode |
| dir_read | input | 1 | 1: DMA read (block drives data), 0: DMA write |
| ack_n | input | 1 | Asynchronous DMA acknowledge, active low |
| rd_n | input | 1 | Asynchronous host read strobe, active low |
| wr_n | input | 1 | Asynchronous host write strobe, active low |
| offset_req | input | OFF_W | Requested synchronous offset |
| dreq | output | 1 | DMA request |
| burst_active | output | 1 | Current request is a burst |
| rd_data_oe | output | 1 | Drive read data onto the host bus |
| bytes_left | output | CNT_W | Remaining bytes of the transfer |
| offset_lim | output | OFF_W | Permitted synchronous offset |

## Verification
The assertions check, on every cycle, that a request rises only when the threshold is met and the acknowledge is idle. They also check that the byte count steps down by one per completed byte, that a burst ends right after its eighth byte and a single request at its acknowledge, that a burst is only demoted by an initiator phase change, and that the offset cap and read-data enable follow the pins. The grouping of a whole transfer into bursts and single tails, for every count and bus mode, is shown only by the bench's sweeps. The same holds for the difference between initiator and target under a phase change.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

   typedef enum logic [1:0] {
      RQ_IDLE   = 2'd0,
      RQ_SINGLE = 2'd1,
      RQ_BURST  = 2'd2
   } req_mode_t;

   typedef struct packed {
      logic ack;
      logic rd;
      logic wr;
   } strobe_t;

endpackage

// File: rtl/dmarq_sync.sv
module dmarq_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dmarq_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[s] <= '1;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q_prev <= '1;
      else q_prev <= chain[STAGES-1];
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/dmarq_count.sv
module dmarq_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] count
);

   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else if (load) count <= load_val;
      else if (dec && (count != '0)) count <= count - CNT_W'(1);
   end

endmodule

// File: rtl/dmarq_gate.sv
module dmarq_gate #(
   parameter int CNT_W     = 16,
   parameter int LVL_W     = 5,
   parameter int OFF_W     = 4,
   parameter int BURST_LEN = 8
) (
   input  logic [CNT_W-1:0] count,
   input  logic [LVL_W-1:0] avail,
   input  logic             deep_thresh_en,
   input  logic             data_phase,
   input  logic             burst_en,
   input  logic [OFF_W-1:0] offset_req,
   output logic             req_ok,
   output logic             burst_ok,
   output logic [OFF_W-1:0] offset_lim
);

   localparam int               BEAT_W  = $clog2(BURST_LEN);
   localparam logic [CNT_W-1:0] BL_C    = CNT_W'(BURST_LEN);
   localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

   logic [CNT_W-1:0] avail_x;
   logic [CNT_W-1:0] need;

   assign avail_x = CNT_W'(avail);

   always_comb begin
      if (deep_thresh_en && data_phase)
         need = (count < BL_C) ? count : BL_C;
      else
         need = ONE_C;
   end

   assign req_ok   = (count != '0) && (avail_x >= need);
   assign burst_ok = burst_en && (count >= BL_C) && (avail_x >= BL_C);

   if (OFF_W > BEAT_W) begin : g_clamp
      localparam logic [OFF_W-1:0] MAX_OFF = OFF_W'(BURST_LEN - 1);
      assign offset_lim = (deep_thresh_en && (offset_req > MAX_OFF)) ? MAX_OFF : offset_req;
   end else begin : g_pass
      logic unused_en;
      assign unused_en  = deep_thresh_en;
      assign offset_lim = offset_req;
   end

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
   import dmarq_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int LVL_W       = 5,
   parameter int OFF_W       = 4,
   parameter int BURST_LEN   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_start,
   input  logic [CNT_W-1:0] xfer_count,
   input  logic [LVL_W-1:0] fifo_avail,
   input  logic             data_phase,
   input  logic             initiator,
   input  logic             phase_change,
   input  logic             deep_thresh_en,
   input  logic             burst_en,
   input  logic             mux_bus,
   input  logic             dir_read,
   input  logic             ack_n,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic [OFF_W-1:0] offset_req,
   output logic             dreq,
   output logic             burst_active,
   output logic             rd_data_oe,
   output logic [CNT_W-1:0] bytes_left,
   output logic [OFF_W-1:0] offset_lim
);

   localparam int               BEAT_W    = $clog2(BURST_LEN);
   localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BURST_LEN - 1);

   if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_burst
      $error("dma_req_ctrl: BURST_LEN must be a power of two of at least 2");
   end
   if (LVL_W > CNT_W || (1 << LVL_W) <= BURST_LEN) begin : g_bad_lvl
      $error("dma_req_ctrl: LVL_W must hold BURST_LEN and fit in CNT_W");
   end

   strobe_t pins, syn, syn_p;
   assign pins = '{ack: ack_n, rd: rd_n, wr: wr_n};

   dmarq_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (pins),
      .q      (syn),
      .q_prev (syn_p)
   );

   logic ack_s, ack_fall, rd_fall, wr_fall, byte_ev;
   assign ack_s    = syn.ack;
   assign ack_fall = !syn.ack && syn_p.ack;
   assign rd_fall  = !syn.rd  && syn_p.rd;
   assign wr_fall  = !syn.wr  && syn_p.wr;

   always_comb begin
      if (!dir_read)    byte_ev = wr_fall && !ack_s;
      else if (mux_bus) byte_ev = rd_fall && !ack_s;
      else              byte_ev = ack_fall;
   end

   dmarq_count #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (xfer_start),
      .load_val (xfer_count),
      .dec      (byte_ev),
      .count    (bytes_left)
   );

   logic req_ok, burst_ok;

   dmarq_gate #(
      .CNT_W(CNT_W), .LVL_W(LVL_W), .OFF_W(OFF_W), .BURST_LEN(BURST_LEN)
   ) u_gate (
      .count          (bytes_left),
      .avail          (fifo_avail),
      .deep_thresh_en (deep_thresh_en),
      .data_phase     (data_phase),
      .burst_en       (burst_en),
      .offset_req     (offset_req),
      .req_ok         (req_ok),
      .burst_ok       (burst_ok),
      .offset_lim     (offset_lim)
   );

   req_mode_t         st;
   logic [BEAT_W-1:0] beat_q;
   logic              acked_q;

   always_ff @(posedge clk) begin
      if (!rst_n || xfer_start) begin
         st      <= RQ_IDLE;
         beat_q  <= '0;
         acked_q <= 1'b0;
      end else begin
         unique case (st)
            RQ_IDLE: begin
               if (req_ok && ack_s) begin
                  st      <= burst_ok ? RQ_BURST : RQ_SINGLE;
                  beat_q  <= '0;
                  acked_q <= 1'b0;
               end
            end
            RQ_SINGLE: begin
               if (ack_fall || (bytes_left == '0)) st <= RQ_IDLE;
            end
            RQ_BURST: begin
               if (ack_fall) acked_q <= 1'b1;
               if (bytes_left == '0) begin
                  st <= RQ_IDLE;
               end else if (byte_ev) begin
                  beat_q <= beat_q + BEAT_W'(1);
                  if (beat_q == BEAT_LAST) st <= RQ_IDLE;
               end else if (phase_change && initiator && !acked_q && !ack_fall) begin
                  st <= RQ_SINGLE;
               end
            end
            default: st <= RQ_IDLE;
         endcase
      end
   end

   assign dreq         = (st != RQ_IDLE);
   assign burst_active = (st == RQ_BURST);
   assign rd_data_oe   = dir_read && !ack_n && (mux_bus ? !rd_n : 1'b1);

endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk #(
   parameter int CNT_W     = 16,
   parameter int LVL_W     = 5,
   parameter int OFF_W     = 4,
   parameter int BURST_LEN = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             xfer_start,
   input logic [LVL_W-1:0] fifo_avail,
   input logic             data_phase,
   input logic             deep_thresh_en,
   input logic             initiator,
   input logic             phase_change,
   input logic             dir_read,
   input logic             mux_bus,
   input logic             ack_n,
   input logic             rd_n,
   input logic [OFF_W-1:0] offset_req,
   input logic             dreq,
   input logic             burst_active,
   input logic             rd_data_oe,
   input logic [CNT_W-1:0] bytes_left,
   input logic [OFF_W-1:0] offset_lim,
   input logic             ack_s,
   input logic             ack_fall,
   input logic             byte_ev,
   input logic [$clog2(BURST_LEN)-1:0] beat_q
);

   localparam logic [CNT_W-1:0] BL_C = CNT_W'(BURST_LEN);
   localparam logic [$clog2(BURST_LEN)-1:0] LAST_B = $clog2(BURST_LEN)'(BURST_LEN - 1);
   localparam logic [OFF_W-1:0] CAP = OFF_W'(BURST_LEN - 1);

   // R1
   deep_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dreq) && $past(deep_thresh_en && data_phase)) |->
      ($past(CNT_W'(fifo_avail)) >= BL_C || $past(CNT_W'(fifo_avail)) >= $past(bytes_left)));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_ev && !xfer_start && bytes_left != '0) |=> (bytes_left == $past(bytes_left) - CNT_W'(1)));

   // R2
   zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq && bytes_left == '0) |=> !dreq);

   // R3
   burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_active && byte_ev && beat_q == LAST_B) |=> !dreq);

   // R3
   burst_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_active |-> dreq);

   // R5
   single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq && !burst_active && ack_fall) |=> !dreq);

   // R5
   idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dreq) |-> $past(ack_s));

   // R6
   demote_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(burst_active) && dreq) |-> $past(phase_change && initiator));

   // R7
   offset_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deep_thresh_en |-> (offset_lim <= CAP && (offset_req > CAP || offset_lim == offset_req)));

   // R9
   oe_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_oe |-> (dir_read && !ack_n && (!mux_bus || !rd_n)));

endmodule

bind dma_req_ctrl dma_req_ctrl_chk #(
   .CNT_W(CNT_W), .LVL_W(LVL_W), .OFF_W(OFF_W), .BURST_LEN(BURST_LEN)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .xfer_start     (xfer_start),
   .fifo_avail     (fifo_avail),
   .data_phase     (data_phase),
   .deep_thresh_en (deep_thresh_en),
   .initiator      (initiator),
   .phase_change   (phase_change),
   .dir_read       (dir_read),
   .mux_bus        (mux_bus),
   .ack_n          (ack_n),
   .rd_n           (rd_n),
   .offset_req     (offset_req),
   .dreq           (dreq),
   .burst_active   (burst_active),
   .rd_data_oe     (rd_data_oe),
   .bytes_left     (bytes_left),
   .offset_lim     (offset_lim),
   .ack_s          (ack_s),
   .ack_fall       (ack_fall),
   .byte_ev        (byte_ev),
   .beat_q         (beat_q)
);

// File: tb/dma_req_ctrl_bench.sv
`timescale 1ns/1ps
module dma_req_ctrl_bench;

   localparam int CNT_W = 16;
   localparam int LVL_W = 5;
   localparam int OFF_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             xfer_start = 1'b0;
   logic [CNT_W-1:0] xfer_count = '0;
   logic [LVL_W-1:0] fifo_avail = '0;
   logic             data_phase = 1'b1;
   logic             initiator = 1'b0;
   logic             phase_change = 1'b0;
   logic             deep_thresh_en = 1'b0;
   logic             burst_en = 1'b0;
   logic             mux_bus = 1'b1;
   logic             dir_read = 1'b0;
   logic             ack_n = 1'b1;
   logic             rd_n = 1'b1;
   logic             wr_n = 1'b1;
   logic [OFF_W-1:0] offset_req = '0;
   logic             dreq, burst_active, rd_data_oe;
   logic [CNT_W-1:0] bytes_left;
   logic [OFF_W-1:0] offset_lim;

   int compared = 0;
   int mismatched = 0;

   always #5 clk = ~clk;

   dma_req_ctrl #(.CNT_W(CNT_W), .LVL_W(LVL_W), .OFF_W(OFF_W)) u_dma_req_ctrl (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_count(xfer_count),
      .fifo_avail(fifo_avail), .data_phase(data_phase), .initiator(initiator),
      .phase_change(phase_change), .deep_thresh_en(deep_thresh_en), .burst_en(burst_en),
      .mux_bus(mux_bus), .dir_read(dir_read), .ack_n(ack_n), .rd_n(rd_n), .wr_n(wr_n),
      .offset_req(offset_req), .dreq(dreq), .burst_active(burst_active),
      .rd_data_oe(rd_data_oe), .bytes_left(bytes_left), .offset_lim(offset_lim)
   );

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic load(input int cnt);
      xfer_count = CNT_W'(cnt);
      xfer_start = 1'b1;
      wait_cyc(1);
      xfer_start = 1'b0;
   endtask

   // Host model: serves one request and checks its byte count
   task automatic serve(input int exp_n, input string req);
      int n = 0;
      int t = 0;
      while (!dreq && t < 60) begin
         wait_cyc(1);
         t++;
      end
      if (!dreq) begin
         chk(1'b0, {req, " request timeout"}, 0, 1);
         return;
      end
      do begin
         if (dir_read && !mux_bus) begin
            if (n > 0) begin
               ack_n = 1'b1;
               wait_cyc(3);
            end
            ack_n = 1'b0;
            wait_cyc(1);
            chk(rd_data_oe == 1'b1, "R10 oe with ack low", int'(rd_data_oe), 1);
         end else begin
            if (n == 0) begin
               ack_n = 1'b0;
               wait_cyc(3);
            end
            if (dir_read) begin
               rd_n = 1'b0;
               wait_cyc(1);
               chk(rd_data_oe == 1'b1, "R9 oe with ack and rd low", int'(rd_data_oe), 1);
               wait_cyc(2);
               rd_n = 1'b1;
               wait_cyc(1);
               chk(rd_data_oe == 1'b0, "R9 oe with rd high", int'(rd_data_oe), 0);
            end else begin
               wr_n = 1'b0;
               wait_cyc(1);
               chk(rd_data_oe == 1'b0, "R8 oe during write", int'(rd_data_oe), 0);
               wait_cyc(2);
               wr_n = 1'b1;
               wait_cyc(1);
            end
         end
         n++;
         wait_cyc(6);
      end while (dreq && n < 16);
      chk(n == exp_n, req, n, exp_n);
      if (!(dir_read && !mux_bus)) begin
         wait_cyc(4);
         chk(dreq == 1'b0, "R5 no request while ack low", int'(dreq), 0);
      end
      ack_n = 1'b1;
      wait_cyc(1);
      if (dir_read && !mux_bus)
         chk(rd_data_oe == 1'b0, "R10 oe with ack high", int'(rd_data_oe), 0);
      wait_cyc(5);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      wait_cyc(4);
      // R11 reset state
      chk(dreq == 1'b0, "R11 dreq in reset", int'(dreq), 0);
      chk(burst_active == 1'b0, "R11 burst in reset", int'(burst_active), 0);
      chk(bytes_left == '0, "R11 count in reset", int'(bytes_left), 0);
      rst_n = 1'b1;
      wait_cyc(3);

      // R7 offset clamp sweep
      for (int th = 0; th < 2; th++) begin
         for (int v = 0; v < 16; v++) begin
            int e;
            deep_thresh_en = th[0];
            offset_req = OFF_W'(v);
            wait_cyc(1);
            e = (th == 1 && v > 7) ? 7 : v;
            chk(int'(offset_lim) == e, "R7 offset clamp", int'(offset_lim), e);
         end
      end

      // R2 zero count never requests
      fifo_avail = 16;
      deep_thresh_en = 1'b0;
      load(0);
      wait_cyc(8);
      chk(dreq == 1'b0, "R2 zero count no request", int'(dreq), 0);

      // R1 threshold sweep, data phase and other phases
      deep_thresh_en = 1'b1;
      for (int d = 0; d < 2; d++) begin
         for (int a = 0; a <= 10; a++) begin
            int e;
            data_phase = d[0];
            fifo_avail = LVL_W'(a);
            load(20);
            wait_cyc(6);
            e = (d == 1) ? int'(a >= 8) : int'(a >= 1);
            chk(int'(dreq) == e, "R1 threshold", int'(dreq), e);
         end
      end
      // R1 tail below eight bytes
      data_phase = 1'b1;
      for (int a = 0; a <= 5; a++) begin
         fifo_avail = LVL_W'(a);
         load(3);
         wait_cyc(6);
         chk(int'(dreq) == int'(a >= 3), "R1 short tail threshold", int'(dreq), int'(a >= 3));
      end
      deep_thresh_en = 1'b0;
      fifo_avail = 16;
      load(0);

      // R3 R4 R8 R9 R10 grouping sweep over bus modes, burst enable, counts
      for (int m = 0; m < 3; m++) begin
         dir_read = (m != 0);
         mux_bus  = (m != 2);
         for (int be = 0; be < 2; be++) begin
            burst_en = be[0];
            for (int c = 1; c <= 12; c++) begin
               int rem;
               load(c);
               rem = c;
               while (rem > 0) begin
                  int g;
                  g = (be == 1 && rem >= 8) ? 8 : 1;
                  serve(g, (g == 8) ? "R3 burst bytes" :
                           (m == 0) ? "R4 R8 single write bytes" :
                           (m == 1) ? "R4 R9 single mux read bytes" : "R4 R10 single nonmux read bytes");
                  rem -= g;
                  chk(int'(bytes_left) == rem, "R2 bytes left", int'(bytes_left), rem);
               end
               wait_cyc(4);
               chk(dreq == 1'b0, "R2 idle at zero count", int'(dreq), 0);
            end
         end
      end

      // R6 initiator phase change before first acknowledge
      dir_read = 1'b0;
      mux_bus  = 1'b1;
      burst_en = 1'b1;
      initiator = 1'b1;
      load(16);
      wait_cyc(6);
      chk(burst_active == 1'b1, "R3 burst started", int'(burst_active), 1);
      phase_change = 1'b1;
      wait_cyc(1);
      phase_change = 1'b0;
      wait_cyc(2);
      chk(burst_active == 1'b0, "R6 initiator demotes burst", int'(burst_active), 0);
      chk(dreq == 1'b1, "R6 request still held", int'(dreq), 1);
      serve(1, "R6 demoted request bytes");

      initiator = 1'b0;
      load(16);
      wait_cyc(6);
      phase_change = 1'b1;
      wait_cyc(1);
      phase_change = 1'b0;
      wait_cyc(2);
      chk(burst_active == 1'b1, "R6 target keeps burst", int'(burst_active), 1);
      serve(8, "R6 target burst bytes");

      // R11 reset mid transfer
      load(10);
      wait_cyc(6);
      rst_n = 1'b0;
      wait_cyc(2);
      chk(dreq == 1'b0 && bytes_left == '0, "R11 reset clears request and count",
          int'(bytes_left), 0);
      rst_n = 1'b1;
      wait_cyc(2);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule